// File: doc/BRIEF.md
# Multi-Slot Sample Playback Mixer

This block plays several stored audio clips at once and folds them into one mixed sample stream. It keeps a table of playback slots, each holding a read pointer into sample memory, an active mark and per-period bookkeeping flags. A trigger path hands the block a clip start address. That address is placed in the next slot in turn, with the pointer skipping the two marker words that open every stored clip.

Every audio sample tick starts a sweep over the slot table, one slot per clock. Each live slot that still lacks data for the current period sends a single memory read tagged with its slot number, and its pointer then moves on by one word. Read data comes back later, in any order, carrying the same tag. The block swaps the two bytes of each returned word, since clips are stored little-endian. It scales the sample down by an arithmetic right shift and adds it into a signed accumulator. On the next tick the accumulator becomes the audio output. A returned word that matches either half of the end-of-clip marker adds nothing, and the next sweep retires that slot.

Top module: `pbmix_top`

## Requirements
- R1: While rst_n is low and after its release, rd_req_o is 0 and audio_o is 0, and every slot is empty.
- R2: A load_i strobe stores load_addr_i + 2 as the slot's word pointer. The first read that slot issues carries that address on rd_addr_o.
- R3: Loads fill slots 0, 1, …, NUM_SLOTS-1 in order, then wrap to slot 0, which overwrites the oldest slot.
- R4: A tick at clock edge E0 starts a sweep. Slot k is examined at edge E(k+1), and its read (if any) is visible on rd_req_o/rd_id_o/rd_addr_o after that edge, with rd_id_o = k. Successive reads within a sweep carry ascending tags.
- R5: An empty slot issues no read. A live slot that has already received a return in the current period issues no read in that period.
- R6: Each issued read advances the slot pointer by exactly one word. The next period's read uses the next address.
- R7: A return adds (swapped word) >>> MIX_SHIFT, taken as signed 16-bit, to the accumulator. The swapped word is {rtn_data_i[7:0], rtn_data_i[15:8]}, and MIX_SHIFT is 3 by default. Contributions from all slots sum.
- R8: audio_o changes only on a tick edge. There it takes the sum built during the period just ended, and the accumulator restarts from zero.
- R9: A return whose raw word is 16'hFEE1 or 16'hDEAD adds zero. That slot is cleared when the next sweep examines it, and it issues no further reads.
- R10: A return tagged with an empty slot, or with a tag of NUM_SLOTS or more, adds nothing to the mix.
- R11: No read is issued in the cycle that directly follows a tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Audio sample tick, one-cycle strobe |
| load_i | input | 1 | Clip start strobe |
| load_addr_i | input | ADDR_W | Clip start word address |
| rd_req_o | output | 1 | Memory read request, one-cycle pulse |
| rd_id_o | output | ID_W | Slot tag of the read |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rtn_valid_i | input | 1 | Read data valid |
| rtn_id_i | input | ID_W | Slot tag of the returned data |
| rtn_data_i | input | 16 | Returned raw little-endian word |
| audio_o | output | ACC_W | Signed mixed sample for the last period |

## Verification
A read for slot k becomes visible k+1 edges after the tick edge: one edge is lost to the tick cycle and one to the output register. The bench therefore drives the tick, samples at the following falling edges, and checks the tag and address at exactly that offset. Returns land in the accumulator at the edge that samples them, so their effect on audio_o shows only after the next tick edge. The bench reads audio_o just after that edge, and once mid-period to confirm the value held. Marker returns are followed through the next sweep, where the cleared slot's turn must show no request.

// File: rtl/pbmix_pkg.sv
// Shared constants and helpers for the playback mixer.
// Assumes 16-bit little-endian stored samples.
package pbmix_pkg;
    localparam int SAMPLE_W = 16;
    localparam logic [SAMPLE_W-1:0] END_MARK_HI = 16'hFEE1;
    localparam logic [SAMPLE_W-1:0] END_MARK_LO = 16'hDEAD;

    // Put a stored little-endian word into sample order.
    function automatic logic [SAMPLE_W-1:0] swap_bytes(input logic [SAMPLE_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction
endpackage

// File: rtl/pbmix_wrap_ctr.sv
// Modulo-LIMIT counter with a synchronous clear.
// Assumes LIMIT >= 2; clear has priority over increment.
module pbmix_wrap_ctr #(
    parameter  int LIMIT = 30,
    localparam int W     = $clog2(LIMIT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count up and return to zero after LIMIT-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= (cnt == W'(LIMIT - 1)) ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/pbmix_accum.sv
// Per-period mix accumulator: adds attenuated signed samples and
// hands the total to the output on each tick. Assumes ACC_W > 16.
module pbmix_accum #(
    parameter int SHIFT = 3,
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    add_en,
    input  logic signed [15:0]      sample,
    output logic signed [ACC_W-1:0] mix_out
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] term;

    // Sign-extend, then attenuate by an arithmetic shift.
    always_comb begin
        ext  = {{(ACC_W-16){sample[15]}}, sample};
        term = ext >>> SHIFT;
    end

    // Accumulate within a period; on a tick, publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            mix_out <= '0;
        end else if (tick) begin
            mix_out <= acc;
            acc     <= add_en ? term : '0;
        end else if (add_en) begin
            acc <= acc + term;
        end
    end
endmodule

// File: rtl/pbmix_top.sv
// Multi-slot playback mixer. Holds a slot table, sweeps it one slot
// per clock after each tick, issues tagged reads and mixes returns.
// Assumes ticks are spaced more than NUM_SLOTS+1 cycles apart, and
// reads are accepted without back-pressure.
module pbmix_top #(
    parameter  int NUM_SLOTS = 30,
    parameter  int ADDR_W    = 27,
    parameter  int MIX_SHIFT = 3,
    localparam int ID_W      = $clog2(NUM_SLOTS),
    localparam int ACC_W     = 16 + ID_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    load_i,
    input  logic [ADDR_W-1:0]       load_addr_i,
    output logic                    rd_req_o,
    output logic [ID_W-1:0]         rd_id_o,
    output logic [ADDR_W-1:0]       rd_addr_o,
    input  logic                    rtn_valid_i,
    input  logic [ID_W-1:0]         rtn_id_i,
    input  logic [15:0]             rtn_data_i,
    output logic signed [ACC_W-1:0] audio_o
);
    import pbmix_pkg::*;

    logic [ADDR_W-1:0]    s_addr [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] s_act, s_got, s_req, s_eof;

    logic            scan_busy, step, scan_last, want_req;
    logic [ID_W-1:0] scan_idx, load_ptr;
    logic            rtn_hit, rtn_end, add_en;

    pbmix_wrap_ctr #(.LIMIT(NUM_SLOTS)) scan_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(tick_i), .inc(step), .cnt(scan_idx)
    );

    pbmix_wrap_ctr #(.LIMIT(NUM_SLOTS)) load_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(load_i), .cnt(load_ptr)
    );

    // Decode the sweep step, the read decision and the return handling.
    always_comb begin
        step      = scan_busy && !tick_i;
        scan_last = (scan_idx == ID_W'(NUM_SLOTS - 1));
        want_req  = step && !s_eof[scan_idx] && s_act[scan_idx]
                    && !s_got[scan_idx] && !s_req[scan_idx];
        rtn_hit   = rtn_valid_i && (rtn_id_i < ID_W'(NUM_SLOTS)) && s_act[rtn_id_i];
        rtn_end   = (rtn_data_i == END_MARK_HI) || (rtn_data_i == END_MARK_LO);
        add_en    = rtn_hit && !rtn_end;
    end

    // Sweep-in-progress flag: set by a tick, dropped after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scan_busy <= 1'b0;
        else if (tick_i)
            scan_busy <= 1'b1;
        else if (step && scan_last)
            scan_busy <= 1'b0;
    end

    // Slot table update: period reset, returns, sweep, then loads win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_act <= '0;
            s_got <= '0;
            s_req <= '0;
            s_eof <= '0;
            for (int i = 0; i < NUM_SLOTS; i++)
                s_addr[i] <= '0;
        end else begin
            if (tick_i) begin
                s_got <= '0;
                s_req <= '0;
            end
            if (rtn_hit) begin
                s_got[rtn_id_i] <= 1'b1;
                if (rtn_end)
                    s_eof[rtn_id_i] <= 1'b1;
            end
            if (step && s_eof[scan_idx]) begin
                s_act[scan_idx] <= 1'b0;
                s_eof[scan_idx] <= 1'b0;
            end else if (want_req) begin
                s_req[scan_idx]  <= 1'b1;
                s_addr[scan_idx] <= s_addr[scan_idx] + ADDR_W'(1);
            end
            if (load_i) begin
                s_addr[load_ptr] <= load_addr_i + ADDR_W'(2);
                s_act[load_ptr]  <= 1'b1;
                s_got[load_ptr]  <= 1'b0;
                s_req[load_ptr]  <= 1'b0;
                s_eof[load_ptr]  <= 1'b0;
            end
        end
    end

    // Registered read request toward the memory side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req_o  <= 1'b0;
            rd_id_o   <= '0;
            rd_addr_o <= '0;
        end else begin
            rd_req_o  <= want_req;
            rd_id_o   <= scan_idx;
            rd_addr_o <= s_addr[scan_idx];
        end
    end

    pbmix_accum #(.SHIFT(MIX_SHIFT), .ACC_W(ACC_W)) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .add_en  (add_en),
        .sample  ($signed(swap_bytes(rtn_data_i))),
        .mix_out (audio_o)
    );
endmodule

// File: rtl/pbmix_chk.sv
// Port-level protocol checks for pbmix_top, attached by bind.
// Assumes the same parameters as the bound instance.
module pbmix_chk #(
    parameter int NUM_SLOTS = 30,
    parameter int ID_W      = 5,
    parameter int ACC_W     = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             rd_req_o,
    input logic [ID_W-1:0]  rd_id_o,
    input logic [ACC_W-1:0] audio_o
);
    // R4
    rd_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_id_o < ID_W'(NUM_SLOTS)));

    // R4
    rd_tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o)) |-> (rd_id_o == $past(rd_id_o) + ID_W'(1)));

    // R11
    no_req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> !rd_req_o);

    // R8
    audio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(audio_o));
endmodule

bind pbmix_top pbmix_chk #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .ACC_W(ACC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .rd_req_o(rd_req_o), .rd_id_o(rd_id_o), .audio_o(audio_o)
);

// File: tb/pbmix_top_tb_top.sv
module pbmix_top_tb_top;
    localparam int ID_W = 5;
    localparam int ADDR_W = 27;
    localparam int ACC_W = 22;
    localparam int NV = 8;
    // Raw returned word and its expected contribution ((swap) >>> 3).
    localparam logic [15:0] VEC_RAW [NV] = '{16'h3412, 16'h00FF, 16'h0180, 16'hFF7F,
                                             16'h0800, 16'h0700, 16'hFFFF, 16'h1000};
    localparam int VEC_EXP [NV] = '{582, -32, -4096, 4095, 1, 0, -1, 2};

    logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, load_i = 1'b0;
    logic [ADDR_W-1:0] load_addr_i = '0;
    logic rd_req_o;
    logic [ID_W-1:0] rd_id_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic rtn_valid_i = 1'b0;
    logic [ID_W-1:0] rtn_id_i = '0;
    logic [15:0] rtn_data_i = '0;
    logic signed [ACC_W-1:0] audio_o;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pbmix_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
        .load_addr_i(load_addr_i), .rd_req_o(rd_req_o), .rd_id_o(rd_id_o),
        .rd_addr_o(rd_addr_o), .rtn_valid_i(rtn_valid_i), .rtn_id_i(rtn_id_i),
        .rtn_data_i(rtn_data_i), .audio_o(audio_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick_i = 1'b1; cyc(1); tick_i = 1'b0;
    endtask

    task automatic do_load(input int addr);
        load_i = 1'b1; load_addr_i = ADDR_W'(addr); cyc(1); load_i = 1'b0;
    endtask

    task automatic do_ret(input int id, input logic [15:0] data);
        rtn_valid_i = 1'b1; rtn_id_i = ID_W'(id); rtn_data_i = data;
        cyc(1); rtn_valid_i = 1'b0;
    endtask

    task automatic exp_req(input int id, input int addr, input string req);
        chk(rd_req_o == 1'b1, req, int'(rd_req_o), 1);
        chk(int'(rd_id_o) == id, req, int'(rd_id_o), id);
        chk(int'(rd_addr_o) == addr, req, int'(rd_addr_o), addr);
    endtask

    task automatic exp_none(input string req);
        chk(rd_req_o == 1'b0, req, int'(rd_req_o), 0);
    endtask

    task automatic exp_audio(input int v, input string req);
        chk(int'(audio_o) == v, req, int'(audio_o), v);
    endtask

    initial begin
        cyc(3);
        exp_none("R1 reset req");
        exp_audio(0, "R1 reset audio");
        rst_n = 1'b1;
        cyc(1);
        exp_none("R1 after release");
        do_load(100);                           // slot 0
        // Table walk: one slot, one return per period.
        for (int i = 0; i < NV; i++) begin
            do_tick();
            if (i > 0) exp_audio(VEC_EXP[i-1], "R7 mix value");
            cyc(1);
            exp_req(0, 102 + i, i == 0 ? "R2 first addr" : "R6 advance");
            do_ret(0, VEC_RAW[i]);
            cyc(30);
        end
        do_tick();
        exp_audio(VEC_EXP[NV-1], "R7 mix value");
        cyc(1);
        exp_req(0, 110, "R6 advance");
        cyc(31);
        // R5: early return blocks the read; R7 sum of three slots.
        do_load(200);                           // slot 1
        do_load(300);                           // slot 2
        do_tick();
        do_ret(2, 16'h0800);                    // lands at E1
        exp_req(0, 111, "R4 slot0 at E1");
        cyc(1);
        exp_req(1, 202, "R4 slot1 at E2");
        cyc(1);
        exp_none("R5 slot2 already fed");
        cyc(30);
        do_ret(0, 16'h1000);
        do_ret(1, 16'h2000);
        exp_audio(0, "R8 hold mid period");
        do_tick();
        exp_audio(7, "R7 three-slot sum");
        cyc(1); exp_req(0, 112, "R6 slot0");
        cyc(1); exp_req(1, 203, "R6 slot1");
        cyc(1); exp_req(2, 302, "R5 slot2 not advanced");
        cyc(30);
        // R9: end markers contribute zero and retire their slots.
        do_ret(1, 16'hDEAD);
        do_ret(2, 16'hFEE1);
        do_ret(0, 16'h1000);
        do_tick();
        exp_audio(2, "R9 marker adds zero");
        cyc(1); exp_req(0, 113, "R9 live slot");
        cyc(1); exp_none("R9 slot1 retired");
        cyc(1); exp_none("R9 slot2 retired");
        cyc(30);
        do_tick();
        exp_audio(0, "R8 empty period");
        cyc(1); exp_req(0, 114, "R9 live slot");
        cyc(1); exp_none("R9 slot1 stays empty");
        cyc(1); exp_none("R9 slot2 stays empty");
        cyc(30);
        // R10: stray tags ignored.
        do_ret(5, 16'h1000);
        do_ret(31, 16'h1000);
        do_ret(0, 16'h1000);
        do_tick();
        exp_audio(2, "R10 stray tags");
        cyc(32);
        // R3: fill slots 3..29, wrap, overwrite slot 0.
        for (int k = 3; k < 30; k++) do_load(1000 + k * 10);
        do_load(5000);
        do_tick();
        cyc(1);
        exp_req(0, 5002, "R3 wrap overwrite");
        begin
            int cnt = 1;
            for (int c = 0; c < 30; c++) begin
                cyc(1);
                if (rd_req_o) begin
                    cnt++;
                    if (rd_id_o == ID_W'(29))
                        chk(int'(rd_addr_o) == 1292, "R4 last slot addr", int'(rd_addr_o), 1292);
                end
            end
            chk(cnt == 28, "R4 reads per sweep", cnt, 28);
        end
        cyc(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule